// File: doc/BRIEF.md
# Stereo Serial Audio FIFO Port

This block is a register-mapped audio peripheral on a simple APB-style bus. Software writes packed stereo words into an 8-entry transmit queue. The block shifts them out as 16-bit samples on a serial data pin. At the same time it shifts incoming samples from a serial input pin into an 8-entry receive queue, which software drains by reading a data register. Each word holds the left sample in bits [31:16] and the right sample in bits [15:0].

The bit clock is the bus clock divided by two. The word-select clock toggles after a programmable number of bit clocks. Each queue has a programmable water level that drives an alert. The alerts, each gated by its own enable, are combined into one interrupt. Overflow and underflow events latch into sticky error bits that software clears by writing 1.

A codec reset pin is driven straight from a control bit. A test mode lets software drive the serial pins and the interrupt directly and read the serial input pin.

Top module: `i2s_audio_port`

## Requirements
- R1: After reset the control register reads 0x00002200 (both water levels 2), the divider reads 0x080, status reads 0x15, error reads 0, and the pins are lrck=1, sclk=0, sdout=0, irq=0, codecRst=0.
- R2: Offsets are control 0x000, status 0x004 (writes ignored), error 0x008, divider 0x00C (10 bits), transmit data 0x010, receive data 0x014, test enable 0x300 (bit 0), test input 0x304, test output 0x308 (4 bits). Control fields read back: bit0 txEn, bit1 txIe, bit2 rxEn, bit3 rxIe, [10:8] tx level, [14:12] rx level, bit16 queue clear, bit17 codec reset. All other bits read 0.
- R3: Each queue holds 8 words. Status bits are: bit0 tx alert, bit1 rx alert, bit2 tx empty, bit3 tx full, bit4 rx empty, bit5 rx full.
- R4: The tx alert is set while the free tx entries exceed the tx level. The rx alert is set while the free rx entries are fewer than the rx level.
- R5: irq is (tx alert AND txIe) OR (rx alert AND rxIe).
- R6: Error bit0 is set by a write to a full tx queue (the word is dropped). It is also set when a frame starts with txEn=1 and an empty tx queue; that frame then sends zeros. Each error bit clears only when 1 is written to it.
- R7: A received word arriving at a full rx queue sets error bit1 and is dropped. The queue keeps its older words.
- R8: sclk runs at half the bus clock while txEn or rxEn is set. lrck toggles every max(divider,17) bit clocks on a falling sclk. While both enables are clear, sclk=0 and lrck=1.
- R9: The left sample goes out while lrck is low and the right sample while lrck is high. Data is MSB first and starts one bit clock after each lrck edge. sdout changes only on a falling sclk and is 0 outside the 16 data slots.
- R10: sdin is sampled on rising sclk in the same slots. With rxEn set, the packed word enters the rx queue after the 16th right bit. Reading offset 0x014 returns the oldest word and removes it; reading an empty queue returns 0.
- R11: While control bit16 is 1, both queues are held empty.
- R12: The codecRst pin equals control bit17.
- R13: When the test enable bit is 1, sdout, sclk, lrck and irq follow test-output bits 0, 1, 2 and 3, and offset 0x304 bit0 reads sdin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and audio clock |
| rstN | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write |
| paddr | input | 12 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| sdin | input | 1 | Serial audio input |
| sdout | output | 1 | Serial audio output |
| sclk | output | 1 | Bit clock |
| lrck | output | 1 | Word-select clock |
| irq | output | 1 | Interrupt |
| codecRst | output | 1 | Codec reset pin |

## Verification
A register write takes effect at the clock edge that ends the access phase. Status, irq, codecRst and the test-mode pins therefore change one cycle later, and the bench reads them in a later bus transfer or at the following falling clock edge. Serial timing is measured from the pins. After an enable, the first lrck fall comes two bus cycles later. Each half-frame then lasts exactly twice the effective divider in bus cycles, and the bench counts falling-edge samples between lrck edges to check this. The rx word is pushed on the 16th right-channel rising sclk, and queue contents are read only after a wait of many whole frames, so no check sits on a boundary cycle.

// File: rtl/i2s_audio_pkg.sv
package i2s_audio_pkg;
  localparam int SAMPLE_W = 16;
  localparam int WORD_W   = 2 * SAMPLE_W;
  localparam int DIV_W    = 10;
  localparam int LVL_W    = 3;

  localparam logic [11:0] OFS_CTRL   = 12'h000;
  localparam logic [11:0] OFS_STAT   = 12'h004;
  localparam logic [11:0] OFS_ERR    = 12'h008;
  localparam logic [11:0] OFS_DIV    = 12'h00C;
  localparam logic [11:0] OFS_TXDATA = 12'h010;
  localparam logic [11:0] OFS_RXDATA = 12'h014;
  localparam logic [11:0] OFS_TSTEN  = 12'h300;
  localparam logic [11:0] OFS_TSTIN  = 12'h304;
  localparam logic [11:0] OFS_TSTOUT = 12'h308;

  // strobes and settings handed from the register block to the datapath
  typedef struct packed {
    logic              txWr;
    logic              rxRd;
    logic [WORD_W-1:0] txData;
    logic              txEn;
    logic              rxEn;
    logic              fifoClr;
    logic [DIV_W-1:0]  lrDiv;
  } dpCtrl_t;
endpackage

// File: rtl/i2s_fifo.sv
module i2s_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && (count != CNT_W'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign popData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/i2s_datapath.sv
module i2s_datapath
  import i2s_audio_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int MIN_HALF = SAMPLE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtl,
  input  logic              sdin,
  output logic              sdout,
  output logic              sclk,
  output logic              lrck,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount,
  output logic [WORD_W-1:0] rxHead,
  output logic              txUnderEv,
  output logic              rxOverEv
);
  logic running, fallEv, riseEv, lastBit, frameStart, framed;
  logic inSlot, nextInSlot, rxDone, txPop, txHasData;
  logic [DIV_W-1:0] halfLen, bitCnt;
  logic [WORD_W-1:0] txShift, rxShift, txHead, rxWord;

  assign running = dpCtl.txEn | dpCtl.rxEn;
  assign halfLen = (dpCtl.lrDiv < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : dpCtl.lrDiv;
  assign fallEv  = running && sclk;
  assign riseEv  = running && !sclk;
  assign lastBit = bitCnt >= (halfLen - 1'b1);
  assign frameStart = fallEv && lastBit && lrck;
  assign txHasData  = (txCount != '0);
  assign txPop      = frameStart && dpCtl.txEn && txHasData;
  assign txUnderEv  = frameStart && dpCtl.txEn && !txHasData;

  assign inSlot     = (bitCnt != '0) && (bitCnt <= DIV_W'(SAMPLE_W));
  assign nextInSlot = bitCnt < DIV_W'(SAMPLE_W);
  assign rxWord     = {rxShift[WORD_W-2:0], sdin};
  assign rxDone     = riseEv && framed && lrck && (bitCnt == DIV_W'(SAMPLE_W)) && dpCtl.rxEn;
  assign rxOverEv   = rxDone && (rxCount == CNT_W'(DEPTH)) && !dpCtl.fifoClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclk    <= 1'b0;
      lrck    <= 1'b1;
      bitCnt  <= '1;
      framed  <= 1'b0;
      sdout   <= 1'b0;
      txShift <= '0;
      rxShift <= '0;
    end else if (!running) begin
      sclk   <= 1'b0;
      lrck   <= 1'b1;
      bitCnt <= '1;
      framed <= 1'b0;
      sdout  <= 1'b0;
    end else begin
      sclk <= !sclk;
      if (fallEv) begin
        if (lastBit) begin
          lrck   <= !lrck;
          bitCnt <= '0;
          sdout  <= 1'b0;
          if (lrck) begin
            framed  <= 1'b1;
            txShift <= txPop ? txHead : '0;
          end
        end else begin
          bitCnt <= bitCnt + 1'b1;
          if (nextInSlot) begin
            sdout   <= txShift[WORD_W-1];
            txShift <= txShift << 1;
          end else begin
            sdout <= 1'b0;
          end
        end
      end
      if (riseEv && framed && inSlot) rxShift <= rxWord;
    end
  end

  i2s_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .clr(dpCtl.fifoClr),
    .push(dpCtl.txWr), .pushData(dpCtl.txData),
    .pop(txPop), .popData(txHead), .count(txCount)
  );

  i2s_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .clr(dpCtl.fifoClr),
    .push(rxDone), .pushData(rxWord),
    .pop(dpCtl.rxRd), .popData(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/i2s_regs.sv
module i2s_regs
  import i2s_audio_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic              sdin,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [WORD_W-1:0] rxHead,
  input  logic              txUnderEv,
  input  logic              rxOverEv,
  output dpCtrl_t           dpCtl,
  output logic              irqNorm,
  output logic              codecRst,
  output logic              itMode,
  output logic [3:0]        itOut,
  output logic [1:0]        errState
);
  logic wrEn, rdEn, txOverWr;
  logic txEn, txIe, rxEn, rxIe, fifoClr;
  logic [LVL_W-1:0] txLvl, rxLvl;
  logic [DIV_W-1:0] lrDiv;
  logic [CNT_W-1:0] txFree, rxFree;
  logic txAlert, rxAlert, txEmpty, txFull, rxEmpty, rxFull;
  logic [1:0] errClr;
  logic unusedHighBits;

  assign wrEn = psel && penable && pwrite;
  assign rdEn = psel && penable && !pwrite;
  assign unusedHighBits = ^pwdata[31:18];

  assign txFree  = CNT_W'(DEPTH) - txCount;
  assign rxFree  = CNT_W'(DEPTH) - rxCount;
  assign txAlert = int'(txFree) > int'(txLvl);
  assign rxAlert = int'(rxFree) < int'(rxLvl);
  assign txEmpty = (txCount == '0);
  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign rxEmpty = (rxCount == '0);
  assign rxFull  = (rxCount == CNT_W'(DEPTH));
  assign irqNorm = (txAlert && txIe) || (rxAlert && rxIe);

  assign txOverWr = dpCtl.txWr && txFull;
  assign errClr   = (wrEn && paddr == OFS_ERR) ? pwdata[1:0] : 2'b00;

  always_comb begin
    dpCtl.txWr    = wrEn && (paddr == OFS_TXDATA);
    dpCtl.rxRd    = rdEn && (paddr == OFS_RXDATA);
    dpCtl.txData  = pwdata;
    dpCtl.txEn    = txEn;
    dpCtl.rxEn    = rxEn;
    dpCtl.fifoClr = fifoClr;
    dpCtl.lrDiv   = lrDiv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn <= 1'b0; txIe <= 1'b0; rxEn <= 1'b0; rxIe <= 1'b0;
      txLvl <= LVL_W'(2); rxLvl <= LVL_W'(2);
      fifoClr <= 1'b0; codecRst <= 1'b0;
      lrDiv <= DIV_W'(10'h080);
      itMode <= 1'b0; itOut <= '0;
      errState <= '0;
    end else begin
      errState <= (errState & ~errClr) | {rxOverEv, txUnderEv | txOverWr};
      if (wrEn) begin
        case (paddr)
          OFS_CTRL: begin
            txEn <= pwdata[0]; txIe <= pwdata[1];
            rxEn <= pwdata[2]; rxIe <= pwdata[3];
            txLvl <= pwdata[10:8]; rxLvl <= pwdata[14:12];
            fifoClr <= pwdata[16]; codecRst <= pwdata[17];
          end
          OFS_DIV:    lrDiv  <= pwdata[DIV_W-1:0];
          OFS_TSTEN:  itMode <= pwdata[0];
          OFS_TSTOUT: itOut  <= pwdata[3:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (paddr)
        OFS_CTRL:   prdata = {14'b0, codecRst, fifoClr, 1'b0, rxLvl, 1'b0, txLvl,
                              4'b0, rxIe, rxEn, txIe, txEn};
        OFS_STAT:   prdata = {26'b0, rxFull, rxEmpty, txFull, txEmpty, rxAlert, txAlert};
        OFS_ERR:    prdata = {30'b0, errState};
        OFS_DIV:    prdata = {{(32-DIV_W){1'b0}}, lrDiv};
        OFS_RXDATA: prdata = rxEmpty ? '0 : rxHead;
        OFS_TSTEN:  prdata = {31'b0, itMode};
        OFS_TSTIN:  prdata = {31'b0, sdin};
        OFS_TSTOUT: prdata = {28'b0, itOut};
        default:    prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/i2s_audio_port.sv
module i2s_audio_port
  import i2s_audio_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [11:0] paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  input  logic        sdin,
  output logic        sdout,
  output logic        sclk,
  output logic        lrck,
  output logic        irq,
  output logic        codecRst
);
  dpCtrl_t dpCtl;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [WORD_W-1:0] rxHead;
  logic txUnderEv, rxOverEv, irqNorm, itMode;
  logic dpSdout, dpSclk, dpLrck;
  logic [3:0] itOut;
  logic [1:0] errState;

  i2s_regs #(.DEPTH(DEPTH)) u_regs (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .sdin(sdin),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .txUnderEv(txUnderEv), .rxOverEv(rxOverEv), .dpCtl(dpCtl),
    .irqNorm(irqNorm), .codecRst(codecRst), .itMode(itMode),
    .itOut(itOut), .errState(errState)
  );

  i2s_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .sdin(sdin),
    .sdout(dpSdout), .sclk(dpSclk), .lrck(dpLrck),
    .txCount(txCount), .rxCount(rxCount), .rxHead(rxHead),
    .txUnderEv(txUnderEv), .rxOverEv(rxOverEv)
  );

  assign sdout = itMode ? itOut[0] : dpSdout;
  assign sclk  = itMode ? itOut[1] : dpSclk;
  assign lrck  = itMode ? itOut[2] : dpLrck;
  assign irq   = itMode ? itOut[3] : irqNorm;
endmodule

// File: rtl/i2s_audio_port_chk.sv
module i2s_audio_port_chk #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [11:0]      paddr,
  input logic [31:0]      pwdata,
  input logic             sclk,
  input logic             lrck,
  input logic             sdout,
  input logic             itMode,
  input logic             running,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic [1:0]       errState
);
  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH)));

  // R8
  lrck_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && !itMode && $past(!itMode) && !$stable(lrck))
      |-> $fell(sclk));

  // R8
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!running) && !itMode) |-> (!sclk && lrck));

  // R9
  sdout_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(running) && !itMode && $past(!itMode) && !$stable(sdout)) |-> $fell(sclk));

  // R6
  tx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errState[0]) |-> $past(psel && penable && pwrite && paddr == 12'h008 && pwdata[0]));

  // R7
  rx_err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(errState[1]) |-> $past(psel && penable && pwrite && paddr == 12'h008 && pwdata[1]));
endmodule

bind i2s_audio_port i2s_audio_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .sclk(sclk), .lrck(lrck), .sdout(sdout),
  .itMode(itMode), .running(dpCtl.txEn | dpCtl.rxEn),
  .txCount(txCount), .rxCount(rxCount), .errState(errState)
);

// File: tb/i2s_audio_port_bench.sv
`timescale 1ns/1ps
module i2s_audio_port_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic sdout, sclk, lrck, irq, codecRst, sdin;
  logic loopBack = 1'b0, sdinDrv = 1'b0;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  assign sdin = loopBack ? sdout : sdinDrv;

  i2s_audio_port u_i2s_audio_port (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .sdin(sdin),
    .sdout(sdout), .sclk(sclk), .lrck(lrck), .irq(irq), .codecRst(codecRst)
  );

  typedef struct packed {
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] expVal;
  } vec_t;

  // R2 register write/read-back vectors
  localparam vec_t VECS [10] = '{
    '{12'h000, 32'h0002_5300, 32'h0002_5300},
    '{12'h000, 32'hFFFF_FFF0, 32'h0003_7700},
    '{12'h000, 32'h0000_2200, 32'h0000_2200},
    '{12'h00C, 32'hFFFF_FFFF, 32'h0000_03FF},
    '{12'h00C, 32'h0000_0014, 32'h0000_0014},
    '{12'h308, 32'hFFFF_FFFF, 32'h0000_000F},
    '{12'h308, 32'h0000_0000, 32'h0000_0000},
    '{12'h300, 32'hFFFF_FFFF, 32'h0000_0001},
    '{12'h300, 32'h0000_0000, 32'h0000_0000},
    '{12'h004, 32'hFFFF_FFFF, 32'h0000_0015}
  };

  function automatic logic [31:0] word(input int i);
    return 32'hC0A5_3C01 ^ (i * 32'h0123_0456);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk); penable = 1'b1; #1 d = prdata;
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  // waits for a low lrck half, counts its bus cycles and grabs 17 sdout bits on rising sclk
  task automatic measureHalf(output int cycles, output logic [16:0] bits);
    int guard = 0;
    int rises = 0;
    logic prevSclk;
    bits = '0; cycles = 0;
    while (lrck !== 1'b1 && guard < 3000) begin @(negedge clk); guard++; end
    while (lrck !== 1'b0 && guard < 6000) begin @(negedge clk); guard++; end
    prevSclk = sclk;
    while (lrck === 1'b0 && cycles < 3000) begin
      @(negedge clk);
      cycles++;
      if (sclk && !prevSclk && rises < 17) begin
        bits = {bits[15:0], sdout};
        rises++;
      end
      prevSclk = sclk;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int cyc;
    logic [16:0] bits;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pins", {27'b0, lrck, sclk, sdout, irq, codecRst}, 32'h10);
    apbRead(12'h000, d); chk("R1 ctrl", d, 32'h0000_2200);
    apbRead(12'h00C, d); chk("R1 div", d, 32'h0000_0080);
    apbRead(12'h004, d); chk("R1 status", d, 32'h0000_0015);
    apbRead(12'h008, d); chk("R1 error", d, 32'h0);

    // R2 vector table
    foreach (VECS[i]) begin
      apbWrite(VECS[i].addr, VECS[i].wdata);
      apbRead(VECS[i].addr, d);
      chk($sformatf("R2 vec%0d", i), d, VECS[i].expVal);
    end

    // R12 codec reset pin
    apbWrite(12'h000, 32'h0002_2200); @(negedge clk);
    chk("R12 high", {31'b0, codecRst}, 32'h1);
    apbWrite(12'h000, 32'h0000_2200); @(negedge clk);
    chk("R12 low", {31'b0, codecRst}, 32'h0);

    // R3 R4 fill the tx queue, alert edge at level 2
    for (int i = 0; i < 5; i++) apbWrite(12'h010, word(i));
    apbRead(12'h004, d); chk("R4 tx alert free3", d, 32'h11);
    apbWrite(12'h010, word(5));
    apbRead(12'h004, d); chk("R4 tx alert free2", d, 32'h10);
    for (int i = 6; i < 8; i++) apbWrite(12'h010, word(i));
    apbRead(12'h004, d); chk("R3 tx full", d, 32'h18);
    apbWrite(12'h010, 32'hDEAD_BEEF);
    apbRead(12'h008, d); chk("R6 write to full", d, 32'h1);
    apbWrite(12'h008, 32'h1);
    apbRead(12'h008, d); chk("R6 w1c", d, 32'h0);

    // R9 R8 R10 loopback run at divider 20
    loopBack = 1'b1;
    apbWrite(12'h000, 32'h0000_2205);
    measureHalf(cyc, bits);
    chk("R8 half period div20", cyc, 32'd40);
    chk("R9 left bits msb first", {15'b0, bits}, {15'b0, 1'b0, word(0)[31:16]});
    repeat (1000) @(negedge clk);
    apbRead(12'h004, d); chk("R3 R4 rx full tx empty", d, 32'h27);
    apbRead(12'h008, d); chk("R6 R7 underrun overrun", d, 32'h3);
    chk("R5 irq masked", {31'b0, irq}, 32'h0);
    apbWrite(12'h000, 32'h0000_2208); @(negedge clk);
    chk("R5 rx irq", {31'b0, irq}, 32'h1);
    apbWrite(12'h000, 32'h0000_2202); @(negedge clk);
    chk("R5 tx irq", {31'b0, irq}, 32'h1);
    apbWrite(12'h000, 32'h0000_2200); @(negedge clk);
    chk("R8 idle pins", {29'b0, lrck, sclk, irq}, 32'h4);
    loopBack = 1'b0;
    for (int i = 0; i < 8; i++) begin
      apbRead(12'h014, d);
      chk($sformatf("R10 R7 rx word%0d", i), d, word(i));
    end
    apbRead(12'h014, d); chk("R10 empty read", d, 32'h0);
    apbRead(12'h004, d); chk("R10 drained", d, 32'h15);

    // R6 R7 per-bit clear
    apbWrite(12'h008, 32'h2);
    apbRead(12'h008, d); chk("R7 w1c bit1", d, 32'h1);
    apbWrite(12'h008, 32'h1);
    apbRead(12'h008, d); chk("R6 w1c bit0", d, 32'h0);

    // R11 queue clear
    for (int i = 0; i < 3; i++) apbWrite(12'h010, word(i));
    apbRead(12'h004, d); chk("R11 before", d, 32'h11);
    apbWrite(12'h000, 32'h0001_2200);
    apbRead(12'h004, d); chk("R11 cleared", d, 32'h15);
    apbWrite(12'h010, word(9));
    apbRead(12'h004, d); chk("R11 held empty", d, 32'h15);
    apbWrite(12'h000, 32'h0000_2200);

    // R13 test mode
    apbWrite(12'h308, 32'hF);
    apbWrite(12'h300, 32'h1); @(negedge clk);
    chk("R13 all high", {28'b0, irq, lrck, sclk, sdout}, 32'hF);
    apbWrite(12'h308, 32'h5); @(negedge clk);
    chk("R13 pattern", {28'b0, irq, lrck, sclk, sdout}, 32'h5);
    sdinDrv = 1'b1;
    apbRead(12'h304, d); chk("R13 sdin one", d, 32'h1);
    sdinDrv = 1'b0;
    apbRead(12'h304, d); chk("R13 sdin zero", d, 32'h0);
    apbWrite(12'h300, 32'h0); @(negedge clk);
    chk("R13 released", {28'b0, irq, lrck, sclk, sdout}, 32'h4);

    // R8 divider clamp to 17
    apbWrite(12'h00C, 32'h5);
    apbWrite(12'h000, 32'h0000_2201);
    measureHalf(cyc, bits);
    chk("R8 clamp div5", cyc, 32'd34);
    apbWrite(12'h000, 32'h0000_2200);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule